// File: doc/BRIEF.md
# Windowed Flash Data FIFOs with Flag-Driven Commit and Release

This block holds the two data queues that sit between a 32-bit register bus and a flash sequencer. Software moves data in fixed 8-byte windows. On the transmit side it writes two 32-bit staging registers, then commits that window into the transmit queue by writing 1 to a flag bit. On the receive side it reads the oldest window through two 32-bit registers, then releases that window by writing 1 to another flag bit. Neither action happens as a side effect of touching a data register.

The sequencer side uses byte streams with valid and ready. Transmit windows are sent least significant byte first, and a window may carry fewer than eight bytes. Receive bytes are packed into windows. A window closes after eight bytes, or earlier when the sequencer marks a byte as the last one.

A flags register shows whether the transmit queue has room and whether receive data is present. It also holds two sticky error bits, and an enable mask selects which flag bits drive the interrupt. Each direction has a clear control and a fill-level readout counted in windows.

Top module: `wm_fifo_pair`

## Requirements
- R1: After reset the flags register (word 0) reads 0x1 (room in the transmit queue only), both level registers read 0, `irq` is 0, `txb_valid` is 0 and `rxb_ready` is 1.
- R2: Writing a 1 to flags bit 0 while the transmit queue is not full appends the staged window. The low word comes from word 6 and the high word from word 7. The transmit level register (word 4) rises by one.
- R3: Each transmit window leaves on `txb_data` one byte per handshake, starting with bits 7:0 of the low word. `txb_last` marks the final byte. The byte count is taken from the transmit control register (word 2) bits 7:4 at commit time; values 1 to 8 are used as given, and 0 or above 8 mean 8. While `txb_ready` is low, `txb_data` holds.
- R4: Flags bit 0 reads 0 once the transmit level equals TX_DEPTH. A commit in that state leaves the level unchanged and sets sticky flags bit 2.
- R5: Eight accepted receive bytes form one window. The first byte appears in bits 7:0 of word 8 and the fifth in bits 7:0 of word 9. Flags bit 1 then reads 1 and the receive level (word 5, bits 15:0) rises by one.
- R6: A byte accepted with `rxb_last` high closes the window early. Bytes it does not fill read 0, and the byte count of the oldest window reads in word 5 bits 19:16 (0 when the queue is empty).
- R7: Writing a 1 to flags bit 1 while receive data is present releases the oldest window: the level drops by one and the next window appears in words 8 and 9.
- R8: A release with the receive queue empty changes nothing else and sets sticky flags bit 3.
- R9: Writing 1 to flags bit 2 or bit 3 clears that error bit. Writing 0 to it leaves it unchanged.
- R10: `irq` is high exactly when some flags bit is 1 and the same bit of the enable register (word 1, bits 3:0) is 1.
- R11: Bit 0 of the transmit control register (word 2) or of the receive control register (word 3), written as 1, empties that queue on the next clock. The receive clear also drops a partly packed window.
- R12: `rxb_ready` is 0 while the receive queue is full, and no byte is taken in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Masked OR of the flag bits |
| txb_valid | output | 1 | Transmit byte available |
| txb_data | output | 8 | Transmit byte |
| txb_last | output | 1 | Final byte of the current transmit window |
| txb_ready | input | 1 | Sequencer takes the transmit byte |
| rxb_valid | input | 1 | Receive byte offered |
| rxb_data | input | 8 | Receive byte |
| rxb_last | input | 1 | Receive byte closes the window |
| rxb_ready | output | 1 | Block accepts the receive byte |

## Verification
The bench builds the block with TX_DEPTH=4 and RX_DEPTH=4 instead of 128 and 64. With these depths a handful of commits or packed windows fills either queue. That brings the full-queue commit, the stalled receive stream, the full flag and both clears within a short run. Byte ordering, short windows and length normalisation are the same at any depth, so these values lose no coverage of the packing logic.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int WIN_BYTES = 8;

  // register word indices
  localparam int A_FLAGS  = 0;
  localparam int A_IRQEN  = 1;
  localparam int A_TXCTL  = 2;
  localparam int A_RXCTL  = 3;
  localparam int A_TXLVL  = 4;
  localparam int A_RXLVL  = 5;
  localparam int A_TXD_LO = 6;
  localparam int A_TXD_HI = 7;
  localparam int A_RXD_LO = 8;
  localparam int A_RXD_HI = 9;

  // flag bit positions
  localparam int F_TX_ROOM  = 0;
  localparam int F_RX_AVAIL = 1;
  localparam int F_TX_ERR   = 2;
  localparam int F_RX_ERR   = 3;

  typedef logic [3:0] wlen_t;

  typedef struct packed {
    wlen_t       len;
    logic [63:0] data;
  } win_t;

  localparam int WIN_W = $bits(win_t);

  // turn a raw length field into a byte count of 1..8
  function automatic wlen_t norm_len(input logic [3:0] raw);
    return (raw == 4'd0 || raw > 4'd8) ? 4'd8 : raw;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [63:0] d, input logic [2:0] idx);
    return d[idx*8 +: 8];
  endfunction

  function automatic logic [63:0] put_byte(input logic [63:0] d, input logic [2:0] idx,
                                           input logic [7:0] b);
    logic [63:0] r;
    r = d;
    r[idx*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/win_fifo.sv
module win_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 68
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // callers gate their requests; a request reaching a full/empty queue is a caller bug
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push && !pop) |=> (count == $past(count) + CW'(1)));
  p_clear_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker
  import wmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  win_t       head,
  input  logic       head_ok,
  output logic       pop,
  output logic       txb_valid,
  output logic [7:0] txb_data,
  output logic       txb_last,
  input  logic       txb_ready
);
  logic [2:0] idx;
  logic       fire;

  assign txb_valid = head_ok;
  assign txb_data  = pick_byte(head.data, idx);
  assign txb_last  = ({1'b0, idx} + 4'd1) == head.len;
  assign fire      = txb_valid && txb_ready;
  assign pop       = fire && txb_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (clr)       idx <= '0;
    else if (fire)      idx <= txb_last ? 3'd0 : idx + 3'd1;
  end

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txb_valid && !txb_ready && !clr) |=> (txb_valid && $stable(txb_data)));
endmodule

// File: rtl/rx_packer.sv
module rx_packer
  import wmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rxb_valid,
  input  logic [7:0] rxb_data,
  input  logic       rxb_last,
  output logic       rxb_ready,
  input  logic       fifo_full,
  output logic       push,
  output win_t       win
);
  logic [2:0]  idx;
  logic [63:0] acc, filled;
  logic        take;

  assign rxb_ready = !fifo_full;
  assign take      = rxb_valid && rxb_ready;
  assign filled    = put_byte(acc, idx, rxb_data);
  assign push      = take && (idx == 3'd7 || rxb_last);
  assign win.len   = {1'b0, idx} + 4'd1;
  assign win.data  = filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (clr) begin
      idx <= '0;
      acc <= '0;
    end else if (take) begin
      if (push) begin
        idx <= '0;
        acc <= '0;
      end else begin
        idx <= idx + 3'd1;
        acc <= filled;
      end
    end
  end

  p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (win.len >= 4'd1 && win.len <= 4'd8));
endmodule

// File: rtl/wm_fifo_pair.sv
module wm_fifo_pair
  import wmf_pkg::*;
#(
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 64,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              txb_valid,
  output logic [7:0]        txb_data,
  output logic              txb_last,
  input  logic              txb_ready,
  input  logic              rxb_valid,
  input  logic [7:0]        rxb_data,
  input  logic              rxb_last,
  output logic              rxb_ready
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  // register state
  logic [31:0] stage_lo, stage_hi;
  logic [3:0]  tx_len_raw, irq_en;
  logic        tx_err, rx_err;

  // named events
  logic wr_flags, commit_req, pop_req, tx_push, rx_pop, tx_clr, rx_clr;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic [TCW-1:0] tx_count;
  logic [RCW-1:0] rx_count;
  logic [WIN_W-1:0] tx_head_raw, rx_head_raw;
  win_t tx_new, tx_head, rx_new, rx_head;
  logic [3:0] flags;

  assign wr_flags   = bus_we && (bus_addr == ADDR_W'(A_FLAGS));
  assign commit_req = wr_flags && bus_wdata[F_TX_ROOM];
  assign pop_req    = wr_flags && bus_wdata[F_RX_AVAIL];
  assign tx_push    = commit_req && !tx_full;
  assign rx_pop     = pop_req && !rx_empty;
  assign tx_clr     = bus_we && (bus_addr == ADDR_W'(A_TXCTL)) && bus_wdata[0];
  assign rx_clr     = bus_we && (bus_addr == ADDR_W'(A_RXCTL)) && bus_wdata[0];

  assign tx_new.len  = norm_len(tx_len_raw);
  assign tx_new.data = {stage_hi, stage_lo};
  assign tx_head     = win_t'(tx_head_raw);
  assign rx_head     = win_t'(rx_head_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo   <= '0;
      stage_hi   <= '0;
      tx_len_raw <= '0;
      irq_en     <= '0;
      tx_err     <= 1'b0;
      rx_err     <= 1'b0;
    end else begin
      if (bus_we && bus_addr == ADDR_W'(A_TXD_LO)) stage_lo   <= bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(A_TXD_HI)) stage_hi   <= bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(A_TXCTL))  tx_len_raw <= bus_wdata[7:4];
      if (bus_we && bus_addr == ADDR_W'(A_IRQEN))  irq_en     <= bus_wdata[3:0];
      // a new error in the same write wins over its clear
      if (commit_req && tx_full)              tx_err <= 1'b1;
      else if (wr_flags && bus_wdata[F_TX_ERR]) tx_err <= 1'b0;
      if (pop_req && rx_empty)                rx_err <= 1'b1;
      else if (wr_flags && bus_wdata[F_RX_ERR]) rx_err <= 1'b0;
    end
  end

  win_fifo #(.DEPTH(TX_DEPTH), .WIDTH(WIN_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .wdata(tx_new), .pop(tx_pop), .rdata(tx_head_raw),
    .full(tx_full), .empty(tx_empty), .count(tx_count)
  );

  tx_unpacker u_tx_out (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .head(tx_head), .head_ok(!tx_empty), .pop(tx_pop),
    .txb_valid(txb_valid), .txb_data(txb_data), .txb_last(txb_last), .txb_ready(txb_ready)
  );

  rx_packer u_rx_in (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .rxb_valid(rxb_valid), .rxb_data(rxb_data), .rxb_last(rxb_last), .rxb_ready(rxb_ready),
    .fifo_full(rx_full), .push(rx_push), .win(rx_new)
  );

  win_fifo #(.DEPTH(RX_DEPTH), .WIDTH(WIN_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .wdata(rx_new), .pop(rx_pop), .rdata(rx_head_raw),
    .full(rx_full), .empty(rx_empty), .count(rx_count)
  );

  always_comb begin
    flags = '0;
    flags[F_TX_ROOM]  = !tx_full;
    flags[F_RX_AVAIL] = !rx_empty;
    flags[F_TX_ERR]   = tx_err;
    flags[F_RX_ERR]   = rx_err;
  end

  assign irq = |(flags & irq_en);

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_FLAGS:  bus_rdata = {28'd0, flags};
      A_IRQEN:  bus_rdata = {28'd0, irq_en};
      A_TXCTL:  bus_rdata = {24'd0, tx_len_raw, 4'd0};
      A_TXLVL:  bus_rdata = 32'(tx_count);
      A_RXLVL:  bus_rdata = 32'(rx_count) | (rx_empty ? 32'd0 : (32'(rx_head.len) << 16));
      A_TXD_LO: bus_rdata = stage_lo;
      A_TXD_HI: bus_rdata = stage_hi;
      A_RXD_LO: bus_rdata = rx_empty ? 32'd0 : rx_head.data[31:0];
      A_RXD_HI: bus_rdata = rx_empty ? 32'd0 : rx_head.data[63:32];
      default:  bus_rdata = '0;
    endcase
  end

  p_err_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && tx_full) |=> tx_err);
  p_err_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && rx_empty) |=> rx_err);
  p_rx_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop && !rx_clr) |=> rx_full);
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'd0) |-> !irq);
endmodule

// File: tb/wm_fifo_pair_bench.sv
module wm_fifo_pair_bench;
  localparam int TXD = 4;
  localparam int RXD = 4;
  localparam logic [3:0] FLAGS = 4'd0, IRQEN = 4'd1, TXCTL = 4'd2, RXCTL = 4'd3,
                         TXLVL = 4'd4, RXLVL = 4'd5, TXLO = 4'd6, TXHI = 4'd7,
                         RXLO = 4'd8, RXHI = 4'd9;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, txb_valid, txb_last, txb_ready = 0;
  logic [7:0] txb_data;
  logic rxb_valid = 0, rxb_last = 0, rxb_ready;
  logic [7:0] rxb_data = '0;

  int errors = 0, checks = 0;
  logic [8:0] txq[$];     // {last, byte}
  logic [67:0] rxq[$];    // {len, hi, lo}

  always #2 clk = ~clk;

  wm_fifo_pair #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(4)) u_wm_fifo_pair (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .txb_valid(txb_valid), .txb_data(txb_data),
    .txb_last(txb_last), .txb_ready(txb_ready), .rxb_valid(rxb_valid), .rxb_data(rxb_data),
    .rxb_last(rxb_last), .rxb_ready(rxb_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, req, v, exp);
  endtask

  // driver: stage, commit and record the bytes the sequencer must see
  task automatic tx_commit(input logic [31:0] lo, input logic [31:0] hi, input int n);
    logic [63:0] d;
    d = {hi, lo};
    wr(TXLO, lo);
    wr(TXHI, hi);
    wr(FLAGS, 32'h1);
    for (int i = 0; i < n; i++) txq.push_back({(i == n - 1), d[i*8 +: 8]});
  endtask

  task automatic tx_drain();
    for (int i = 0; i < 200 && (txq.size() != 0 || txb_valid); i++) @(negedge clk);
    chk(txq.size() == 0, "R3 drain", 32'(txq.size()), 0);
  endtask

  // monitor: compare each handshaked byte with the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rst_n && txb_valid && txb_ready) begin
      if (txq.size() == 0) chk(0, "R3 unexpected byte", {23'd0, txb_last, txb_data}, 0);
      else begin
        logic [8:0] e;
        e = txq.pop_front();
        chk({txb_last, txb_data} === e, "R3 byte", {23'd0, txb_last, txb_data}, {23'd0, e});
      end
    end
  end

  task automatic rx_byte(input logic [7:0] d, input logic last);
    @(negedge clk);
    rxb_valid = 1; rxb_data = d; rxb_last = last;
    #1;
    while (!rxb_ready) begin @(negedge clk); #1; end
  endtask

  task automatic rx_idle();
    @(negedge clk);
    rxb_valid = 0; rxb_last = 0;
  endtask

  // driver: send n bytes starting at base, closing with last when n < 8
  task automatic rx_send(input logic [7:0] base, input int n);
    logic [63:0] d;
    d = '0;
    for (int i = 0; i < n; i++) begin
      rx_byte(base + 8'(i), (n < 8) && (i == n - 1));
      d[i*8 +: 8] = base + 8'(i);
    end
    rx_idle();
    rxq.push_back({4'(n), d});
  endtask

  task automatic rx_check_head(input string req);
    logic [67:0] e;
    e = rxq.pop_front();
    rd_chk(RXLO, e[31:0], req);
    rd_chk(RXHI, e[63:32], req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk(FLAGS, 32'h1, "R1 flags");
    rd_chk(TXLVL, 32'h0, "R1 tx level");
    rd_chk(RXLVL, 32'h0, "R1 rx level");
    chk(irq === 0 && txb_valid === 0 && rxb_ready === 1, "R1 pins",
        {29'd0, irq, txb_valid, rxb_ready}, 32'h1);

    // R2 commit raises level, R3 full window order (length 0 means 8)
    tx_commit(32'h44332211, 32'h88776655, 8);
    rd_chk(TXLVL, 32'h1, "R2 level after commit");
    @(negedge clk); txb_ready = 1;
    tx_drain();
    rd_chk(TXLVL, 32'h0, "R2 level after drain");

    // R3 short window of 3, and 12 normalised to 8
    wr(TXCTL, 32'h30);
    tx_commit(32'hCCBBAA99, 32'h0, 3);
    tx_drain();
    wr(TXCTL, 32'hC0);
    tx_commit(32'h03020100, 32'h07060504, 8);
    tx_drain();

    // R4 full queue
    @(negedge clk); txb_ready = 0;
    wr(TXCTL, 32'h20);
    for (int i = 0; i < TXD; i++) tx_commit(32'h10 * i, 32'h0, 2);
    rd_chk(TXLVL, 32'(TXD), "R4 level at full");
    rd_chk(FLAGS, 32'h0, "R4 room cleared");
    wr(FLAGS, 32'h1);
    rd_chk(TXLVL, 32'(TXD), "R4 level after refused commit");
    rd_chk(FLAGS, 32'h4, "R4 error set");

    // R10 interrupt mask
    wr(IRQEN, 32'h4);
    @(negedge clk); #1 chk(irq === 1, "R10 irq enabled", {31'd0, irq}, 1);
    wr(IRQEN, 32'h2);
    @(negedge clk); #1 chk(irq === 0, "R10 irq masked", {31'd0, irq}, 0);

    // R9 write-one-to-clear
    wr(FLAGS, 32'h0);
    rd_chk(FLAGS, 32'h4, "R9 zero write keeps error");
    wr(FLAGS, 32'h4);
    rd_chk(FLAGS, 32'h0, "R9 one write clears error");

    // R11 transmit clear
    wr(TXCTL, 32'h21);
    txq.delete();
    rd_chk(TXLVL, 32'h0, "R11 tx level after clear");
    chk(txb_valid === 0, "R11 tx stream idle", {31'd0, txb_valid}, 0);
    @(negedge clk); txb_ready = 1;
    tx_commit(32'hDEADBEEF, 32'h0, 2);
    tx_drain();

    // R5 full receive window
    rx_send(8'hA0, 8);
    rd_chk(RXLVL, 32'h0008_0001, "R5 level and length");
    rd_chk(FLAGS, 32'h3, "R5 rx available");
    rx_check_head("R5 window data");
    // R7 release
    wr(FLAGS, 32'h2);
    rd_chk(RXLVL, 32'h0, "R7 level after release");
    rd_chk(FLAGS, 32'h1, "R7 available cleared");

    // R6 short window, then R7 release order with two windows
    rx_send(8'hB0, 3);
    rx_send(8'hE0, 5);
    rd_chk(RXLVL, 32'h0003_0002, "R6 short length");
    rx_check_head("R6 short data");
    wr(FLAGS, 32'h2);
    rd_chk(RXLVL, 32'h0005_0001, "R7 next window length");
    rx_check_head("R7 next window data");
    wr(FLAGS, 32'h2);

    // R8 release from empty
    wr(FLAGS, 32'h2);
    rd_chk(RXLVL, 32'h0, "R8 level stays 0");
    rd_chk(FLAGS, 32'h9, "R8 error set");
    wr(IRQEN, 32'h8);
    @(negedge clk); #1 chk(irq === 1, "R10 rx error irq", {31'd0, irq}, 1);
    wr(FLAGS, 32'h8);
    rd_chk(FLAGS, 32'h1, "R9 rx error cleared");
    @(negedge clk); #1 chk(irq === 0, "R10 irq low after clear", {31'd0, irq}, 0);

    // R12 stall on full receive queue
    for (int i = 0; i < RXD; i++) rx_send(8'(8'h40 + 8 * i), 8);
    rd_chk(RXLVL, 32'h0008_0000 | 32'(RXD), "R12 full level");
    chk(rxb_ready === 0, "R12 ready low", {31'd0, rxb_ready}, 0);
    @(negedge clk); rxb_valid = 1; rxb_data = 8'h77;
    repeat (3) @(negedge clk);
    rxb_valid = 0;
    rd_chk(RXLVL, 32'h0008_0000 | 32'(RXD), "R12 no byte taken");
    rx_check_head("R12 head intact");

    // R11 receive clear, including a partial window
    wr(RXCTL, 32'h1);
    rxq.delete();
    rd_chk(RXLVL, 32'h0, "R11 rx level after clear");
    rx_byte(8'h55, 0); rx_byte(8'h66, 0); rx_idle();
    wr(RXCTL, 32'h1);
    rx_send(8'hC0, 8);
    rd_chk(RXLVL, 32'h0008_0001, "R11 fresh window only");
    rx_check_head("R11 partial bytes dropped");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule